// File: doc/BRIEF.md
# Polarity-Steered PWM Gate Sequencer

This block drives the six gate commands of a single-stage bidirectional AC-AC regulator that can raise or lower the line voltage and deliver it either in phase or in anti-phase. A free-running carrier counter and a comparator make one high-frequency PWM waveform. Steering logic then sends that waveform to one of the six gates. The target gate depends on the present half-cycle of the line, on the conversion mode (step-down or step-up) and on the requested output polarity. The other five gates are held at line-frequency levels.

A one-bit line-polarity sense goes through a synchronizer and a stability filter before the steering logic uses it. The mode select, the invert select and the duty word are captured only at the end of a carrier period, so a change made part-way through a period cannot cut a pulse short. Supervisory control picks step-down when the needed correction is below half of nominal and step-up when it is above. The ideal gain is D in step-down and 1/(1−D) in step-up. Complementary gates change on the same clock edge with no dead band, because the power stage tolerates overlapping on-states.

Top module: `pwm_gate_sequencer`

## Requirements
- R1: While `rst` is high, every bit of `gate_o` is 0 from the next clock edge on. Bit i−1 of `gate_o` is gate c_i (bit 0 = c1, bit 5 = c6).
- R2: In step-down, non-inverting mode (`boost_i`=0, `invert_i`=0) with positive line: c1 carries the PWM, c2, c3 and c6 are 1, and c4 and c5 are 0.
- R3: In step-down, non-inverting mode with negative line: c3 carries the PWM, c1, c4 and c5 are 1, and c2 and c6 are 0.
- R4: In step-down, inverting mode, c1 and c3 behave as in R2/R3. With positive line c4 and c5 are 1 and c2 and c6 are 0. With negative line c2 and c6 are 1 and c4 and c5 are 0.
- R5: In step-up, non-inverting mode with positive line: c1, c2 and c6 are 1, c5 carries the PWM, and c3 and c4 are 0. With negative line: c3, c4 and c5 are 1, c6 carries the PWM, and c1 and c2 are 0.
- R6: In step-up, inverting mode with positive line: c1, c4 and c5 are 1, c6 carries the PWM, and c2 and c3 are 0. With negative line: c2, c3 and c6 are 1, c5 carries the PWM, and c1 and c4 are 0.
- R7: With steady inputs, the PWM-carrying gate is high for exactly min(`duty_i`, PERIOD_CYC) cycles in any PERIOD_CYC consecutive cycles. A duty of 0 keeps it low and a duty of PERIOD_CYC or more keeps it high.
- R8: A change of `pol_pos_i` that lasts fewer than FILT_LEN cycles does not alter `gate_o`. A sustained change shows on `gate_o` no later than FILT_LEN+4 clock cycles after it is applied.
- R9: `boost_i`, `invert_i` and `duty_i` are captured only at the carrier wrap. With the counter starting at 0 after reset, the wrap falls on every PERIOD_CYC-th clock edge, and gate levels follow the new setting from the edge after that wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_pos_i | input | 1 | Line-polarity sense, 1 = positive half-cycle (asynchronous) |
| boost_i | input | 1 | Conversion mode, 0 = step-down, 1 = step-up |
| invert_i | input | 1 | Output polarity, 1 = anti-phase output |
| duty_i | input | DUTY_W | PWM on-time in carrier counts |
| gate_o | output | 6 | Gate commands c1..c6 on bits 0..5 |

## Verification
The bench drives all four combinations of mode and invert select, each in both half-cycles. A wrong entry in any steering table therefore shows up as a mismatch in a specific gate at a specific polarity. Duty words of 0, a mid value, exactly the period and above the period separate a correct comparator from off-by-one or overflow faults. A two-cycle polarity glitch and a sustained flip are applied to tell the stability filter apart from a bare synchronizer. A mode change placed at a known carrier phase shows whether the capture waits for the wrap.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef struct packed {
        logic step_up;
        logic anti_phase;
    } cfg_t;

    typedef struct packed {
        logic c6;
        logic c5;
        logic c4;
        logic c3;
        logic c2;
        logic c1;
    } gates_t;

    localparam cfg_t CFG_RESET = '{step_up: 1'b0, anti_phase: 1'b0};

    // Route the PWM and the line-frequency levels to the six gates.
    // fwd is 1 when the output leg should conduct in the "c2/c6" direction.
    function automatic gates_t route_gates(input logic pos, input cfg_t cfg, input logic pwm);
        gates_t g;
        logic   fwd;
        fwd = pos ^ cfg.anti_phase;
        if (!cfg.step_up) begin
            g.c1 = pos ? pwm : 1'b1;
            g.c3 = pos ? 1'b1 : pwm;
            g.c2 = fwd;
            g.c6 = fwd;
            g.c4 = !fwd;
            g.c5 = !fwd;
        end else begin
            g.c1 = pos;
            g.c3 = !pos;
            g.c2 = fwd;
            g.c4 = !fwd;
            g.c5 = fwd ? pwm : 1'b1;
            g.c6 = fwd ? 1'b1 : pwm;
        end
        return g;
    endfunction

endpackage

// File: rtl/pol_filter.sv
module pol_filter #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic pol_o
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic             sync1, sync2;
    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_o   <= 1'b0;
            run_cnt <= '0;
        end else if (sync2 == pol_o) begin
            run_cnt <= '0;
        end else if (run_cnt == RUN_W'(FILT_LEN - 1)) begin
            pol_o   <= sync2;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // A new filtered value must be one the synchronizer actually presented.
    assert_filter_src_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(pol_o) |-> (pol_o == $past(sync2)));

endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 2000,
    parameter int DUTY_W     = $clog2(PERIOD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    input  cfg_t              cfg_i,
    output logic              pwm_o,
    output cfg_t              cfg_o
);
    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_q;
    logic              wrap;

    assign wrap = (cnt == CNT_W'(PERIOD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            duty_q <= '0;
            cfg_o  <= CFG_RESET;
        end else if (wrap) begin
            cnt    <= '0;
            duty_q <= duty_i;
            cfg_o  <= cfg_i;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwm_o = (DUTY_W'(cnt) < duty_q);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> ($stable(duty_q) && $stable(cfg_o)));

    assert_zero_duty_R7: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !pwm_o);

endmodule

// File: rtl/gate_steer.sv
module gate_steer
    import gate_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pos_i,
    input  cfg_t   cfg_i,
    input  logic   pwm_i,
    output gates_t gates_o
);
    always_ff @(posedge clk) begin
        if (rst) gates_o <= '0;
        else     gates_o <= route_gates(pos_i, cfg_i, pwm_i);
    end

    // At least one front-stage device conducts in every mode.
    assert_front_on_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gates_o.c1 || gates_o.c3));

    // The c2 and c4 legs are never on together and never both off.
    assert_leg_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $onehot({gates_o.c2, gates_o.c4}));

    // In step-up the front stage is a pure rectifier: one side only.
    assert_boost_front_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_i.step_up)) |-> $onehot({gates_o.c1, gates_o.c3}));

endmodule

// File: rtl/pwm_gate_sequencer.sv
module pwm_gate_sequencer
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 2000,
    parameter int FILT_LEN   = 16,
    parameter int DUTY_W     = $clog2(PERIOD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pol_pos_i,
    input  logic              boost_i,
    input  logic              invert_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [5:0]        gate_o
);
    logic   pol_clean;
    logic   pwm;
    cfg_t   cfg_req, cfg_live;
    gates_t gates;

    assign cfg_req = '{step_up: boost_i, anti_phase: invert_i};

    pol_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pol_pos_i),
        .pol_o (pol_clean)
    );

    pwm_carrier #(.PERIOD_CYC(PERIOD_CYC), .DUTY_W(DUTY_W)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_i),
        .cfg_i  (cfg_req),
        .pwm_o  (pwm),
        .cfg_o  (cfg_live)
    );

    gate_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .pos_i   (pol_clean),
        .cfg_i   (cfg_live),
        .pwm_i   (pwm),
        .gates_o (gates)
    );

    assign gate_o = gates;

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (gate_o == 6'b0));

endmodule

// File: tb/pwm_gate_sequencer_tb.sv
module pwm_gate_sequencer_tb_top;
    localparam int P      = 10;
    localparam int FL     = 4;
    localparam int DW     = $clog2(P + 1);

    typedef struct {
        logic [5:0] val;
        logic [5:0] mask;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pol = 1'b1;
    logic          boost = 1'b0;
    logic          inv = 1'b0;
    logic [DW-1:0] duty = DW'(4);
    logic [5:0]    gate_o;

    int   n_checks = 0;
    int   n_errors = 0;
    int   edge_n = 0;
    bit   done = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    pwm_gate_sequencer #(.PERIOD_CYC(P), .FILT_LEN(FL), .DUTY_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pol_pos_i (pol),
        .boost_i   (boost),
        .invert_i  (inv),
        .duty_i    (duty),
        .gate_o    (gate_o)
    );

    // Monitor: compare every queued expectation at the next falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if ((gate_o & e.mask) !== (e.val & e.mask)) begin
                n_errors++;
                $display("FAIL %s: gate_o=%b expected=%b mask=%b", e.tag, gate_o, e.val, e.mask);
            end
        end
    end

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic expect_g(input logic [5:0] v, input logic [5:0] m, input string tag);
        exp_t e;
        e.val = v; e.mask = m; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic count_bit(input int idx, input int exp_cnt, input string tag);
        int ones = 0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (gate_o[idx]) ones++;
        end
        n_checks++;
        if (ones != exp_cnt) begin
            n_errors++;
            $display("FAIL %s: high cycles=%0d expected=%0d", tag, ones, exp_cnt);
        end
        #1;
    endtask

    task automatic wait_phase(input int ph);
        do step(1); while ((edge_n % P) != ph);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs low during reset
        step(3);
        expect_g(6'b000000, 6'b111111, "R1 reset");
        step(1);
        rst = 1'b0;
        step(4 * P);

        // R2: step-down, non-inverting, positive line (c1 PWM)
        expect_g(6'b100110, 6'b111110, "R2 levels");
        step(1);
        count_bit(0, 4, "R2/R7 c1 duty 4");

        // R7: duty boundaries
        duty = DW'(0);  step(2 * P + 2); count_bit(0, 0, "R7 duty 0");
        duty = DW'(P);  step(2 * P + 2); count_bit(0, P, "R7 duty full");
        duty = DW'(15); step(2 * P + 2); count_bit(0, P, "R7 duty above period");
        duty = DW'(3);  step(2 * P + 2); count_bit(0, 3, "R7 duty 3");
        duty = DW'(4);  step(2 * P + 2);

        // R3 and R8 sustained flip: negative line
        pol = 1'b0;
        step(FL + 4);
        expect_g(6'b011001, 6'b111011, "R3/R8 levels after flip");
        step(1);
        count_bit(2, 4, "R3 c3 duty");

        // R4: step-down inverting, both half-cycles
        inv = 1'b1;
        step(2 * P + 2);
        expect_g(6'b100011, 6'b111011, "R4 negative");
        step(1);
        pol = 1'b1;
        step(FL + 4);
        expect_g(6'b011100, 6'b111110, "R4 positive");
        step(1);
        count_bit(0, 4, "R4 c1 duty");

        // R5: step-up non-inverting
        inv = 1'b0; boost = 1'b1;
        step(2 * P + 2);
        expect_g(6'b100011, 6'b101111, "R5 positive");
        step(1);
        count_bit(4, 4, "R5 c5 duty");
        pol = 1'b0;
        step(FL + 4);
        expect_g(6'b011100, 6'b011111, "R5 negative");
        step(1);
        count_bit(5, 4, "R5 c6 duty");

        // R6: step-up inverting
        inv = 1'b1;
        step(2 * P + 2);
        expect_g(6'b100110, 6'b101111, "R6 negative");
        step(1);
        count_bit(4, 4, "R6 c5 duty");
        pol = 1'b1;
        step(FL + 4);
        expect_g(6'b011001, 6'b011111, "R6 positive");
        step(1);
        count_bit(5, 4, "R6 c6 duty");

        // R8: short glitch on polarity is ignored (c1 stays 1)
        pol = 1'b0;
        step(2);
        pol = 1'b1;
        for (int i = 0; i < 12; i++) begin
            expect_g(6'b011001, 6'b011111, "R8 glitch ignored");
            step(1);
        end

        // R9: mode capture waits for carrier wrap
        boost = 1'b0; inv = 1'b0;
        step(2 * P + 2);
        pol = 1'b0;
        step(FL + 6);
        wait_phase(2);
        boost = 1'b1;
        wait_phase(0);
        expect_g(6'b000001, 6'b000001, "R9 old mode held until wrap");
        step(1);
        expect_g(6'b000000, 6'b000001, "R9 new mode after wrap");
        step(1);

        // R1: reset in mid-run clears outputs
        rst = 1'b1;
        step(1);
        expect_g(6'b000000, 6'b111111, "R1 mid-run reset");
        step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule